// File: doc/BRIEF.md
# Interrupt Vector Selection Controller

This block chooses the next program counter value for a small microcontroller with an 11-bit program counter. It latches four interrupt request sources into pending flags and gates them with a global enable and a stack-full flag from the call stack. When an interrupt is taken, it produces a fixed vector address, a strobe that loads it, a push request for the return address and an acknowledge for the source being serviced.

The four sources are the external pin, the time base overflow, the real-time clock overflow, and a timer overflow that two timers share. Vectors sit four words apart. The instruction decoder drives the enable set and clear inputs and may drop pending flags directly. The stack and the program memory are outside this block.

Top module: `irq_vector_sel`

## Requirements
- R1: In the first cycle after reset is released, `vec_take` is 1 and `vec_addr` is 0x000, while `push_req` and `ack` are 0. After that cycle the boot strobe does not repeat.
- R2: A serviced source drives `vec_addr` to a fixed address. The external pin goes to 0x004, the time base to 0x008, the real-time clock to 0x00C, and timer A or timer B to the shared 0x010. Bits of `pending` and `ack` use the same order: bit0 external, bit1 time base, bit2 real-time clock, bit3 timer.
- R3: A request input that is high at a clock edge sets its pending bit, which is visible from the next cycle. The bit stays set until it is serviced or cleared.
- R4: An interrupt is taken only in a cycle where `ie` is 1, `stack_full` is 0 and at least one pending bit is set.
- R5: When several bits are pending, the lowest bit wins. The order is external, then time base, then real-time clock, then timer.
- R6: In a take cycle, `push_req` and `vec_take` are 1 and `ack` has exactly the granted bit set. In cycles without a take, `push_req` and `ack` are 0 and `vec_addr` is 0.
- R7: `ie_set` sets `ie` and `ie_clr` clears it, with set winning over clear. Taking an interrupt clears `ie` at the next edge and overrides `ie_set`.
- R8: A take clears only the serviced pending bit. If a request for the same source is present at that edge, the bit stays set.
- R9: While `stack_full` is 1, no take occurs and every pending bit is kept.
- R10: A `pend_clr` bit clears the matching pending bit at the next edge. A request for the same source in the same cycle keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_ext | input | 1 | External pin request |
| req_tbase | input | 1 | Time base overflow request |
| req_rtc | input | 1 | Real-time clock overflow request |
| req_tmr_a | input | 1 | Timer A overflow request |
| req_tmr_b | input | 1 | Timer B overflow request |
| ie_set | input | 1 | Set global interrupt enable |
| ie_clr | input | 1 | Clear global interrupt enable |
| stack_full | input | 1 | Call stack has no free entry |
| pend_clr | input | 4 | Per-source pending clear |
| vec_addr | output | PC_W | Next program counter value |
| vec_take | output | 1 | Load `vec_addr` into the program counter |
| push_req | output | 1 | Push the return address |
| ack | output | 4 | One-hot acknowledge of the serviced source |
| pending | output | 4 | Pending flags |
| ie | output | 1 | Global interrupt enable state |

## Verification
The hardest case to reach is a take with several sources already pending, because priority only shows when the flags pile up while the controller is blocked. The bench first sets each of the 16 pending patterns with the enable off. It then opens the gate under every combination of enable and stack-full, and checks the granted vector and which flags remain. A separate drain sequence re-enables interrupts after each take and confirms that all four vectors come out in priority order. Further cases apply a new request or a clear in the same cycle as a take.

// File: rtl/irq_vector_sel.sv
module irq_vector_sel #(
  parameter int PC_W   = 11,
  parameter int STRIDE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_ext,
  input  logic            req_tbase,
  input  logic            req_rtc,
  input  logic            req_tmr_a,
  input  logic            req_tmr_b,
  input  logic            ie_set,
  input  logic            ie_clr,
  input  logic            stack_full,
  input  logic [3:0]      pend_clr,
  output logic [PC_W-1:0] vec_addr,
  output logic            vec_take,
  output logic            push_req,
  output logic [3:0]      ack,
  output logic [3:0]      pending,
  output logic            ie
);
  localparam int NSRC = 4;

  logic [NSRC-1:0] raw, pend_q, grant;
  logic [PC_W-1:0] vec_sel;
  logic            boot_q, ie_q, take_irq;

  assign raw   = {req_tmr_a | req_tmr_b, req_rtc, req_tbase, req_ext};
  assign grant = pend_q & (~pend_q + NSRC'(1));

  always_comb begin
    vec_sel = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) vec_sel = PC_W'((i + 1) * STRIDE);
  end

  assign take_irq = ie_q & ~stack_full & ~boot_q & (|pend_q);
  assign vec_take = boot_q | take_irq;
  assign push_req = take_irq;
  assign ack      = take_irq ? grant : '0;
  assign vec_addr = take_irq ? vec_sel : '0;
  assign pending  = pend_q;
  assign ie       = ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      ie_q   <= 1'b0;
      pend_q <= '0;
    end else begin
      boot_q <= 1'b0;
      pend_q <= (pend_q & ~ack & ~pend_clr) | raw;
      if (take_irq)    ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;
      else if (ie_clr) ie_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vector_sel_sva.sv
module irq_vector_sel_sva #(
  parameter int PC_W   = 11,
  parameter int STRIDE = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stack_full,
  input logic [3:0]      pend_clr,
  input logic [PC_W-1:0] vec_addr,
  input logic            vec_take,
  input logic            push_req,
  input logic [3:0]      ack,
  input logic [3:0]      pending,
  input logic            ie
);
  p_push_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> (ie && !stack_full && pending != 4'd0));

  p_ack_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack) && (push_req == (ack != 4'd0)) && (!push_req || vec_take));

  p_vec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |-> (vec_addr != '0 && (vec_addr % STRIDE) == 0 && vec_addr <= PC_W'(4 * STRIDE)));

  p_take_clears_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> !ie);

  p_full_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_full && pend_clr == 4'd0) |=> ((pending & $past(pending)) == $past(pending)));

  p_ack_was_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & pending) == ack));
endmodule

bind irq_vector_sel irq_vector_sel_sva #(.PC_W(PC_W), .STRIDE(STRIDE)) u_sva (
  .clk(clk), .rst_n(rst_n), .stack_full(stack_full), .pend_clr(pend_clr),
  .vec_addr(vec_addr), .vec_take(vec_take), .push_req(push_req), .ack(ack),
  .pending(pending), .ie(ie)
);

// File: tb/irq_vector_sel_tb.sv
`timescale 1ns/1ps
module irq_vector_sel_tb;
  logic clk = 0, rst_n = 0;
  logic req_ext = 0, req_tbase = 0, req_rtc = 0, req_tmr_a = 0, req_tmr_b = 0;
  logic ie_set = 0, ie_clr = 0, stack_full = 0;
  logic [3:0] pend_clr = 0;
  logic [10:0] vec_addr;
  logic vec_take, push_req, ie;
  logic [3:0] ack, pending;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_sel u_dut (
    .clk(clk), .rst_n(rst_n), .req_ext(req_ext), .req_tbase(req_tbase),
    .req_rtc(req_rtc), .req_tmr_a(req_tmr_a), .req_tmr_b(req_tmr_b),
    .ie_set(ie_set), .ie_clr(ie_clr), .stack_full(stack_full), .pend_clr(pend_clr),
    .vec_addr(vec_addr), .vec_take(vec_take), .push_req(push_req), .ack(ack),
    .pending(pending), .ie(ie)
  );

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_req(input logic [3:0] p, input bit use_b);
    req_ext = p[0]; req_tbase = p[1]; req_rtc = p[2];
    req_tmr_a = p[3] & ~use_b; req_tmr_b = p[3] & use_b;
  endtask

  task automatic do_reset;
    rst_n = 0; drive_req(4'd0, 0); ie_set = 0; ie_clr = 0; stack_full = 0; pend_clr = 0;
    tick; tick;
    rst_n = 1; #1;
    check("R1 boot take", vec_take, 1);
    check("R1 boot addr", vec_addr, 0);
    check("R1 boot push/ack", {push_req, ack}, 0);
    tick; #1;
    check("R1 boot once", vec_take, 0);
  endtask

  function automatic int low_idx(input logic [3:0] p);
    for (int i = 3; i >= 0; i--) if (p[i]) low_idx = i;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset;
    check("R3 reset pending", pending, 0);
    check("R7 reset ie", ie, 0);

    for (int p = 0; p < 16; p++)
      for (int e = 0; e < 2; e++)
        for (int f = 0; f < 2; f++) begin
          bit take; int idx; logic [3:0] g;
          do_reset;
          drive_req(4'(p), bit'(e ^ f));
          tick; drive_req(4'd0, 0); #1;
          check("R3 latch", pending, p);
          check("R4 no take ie=0", vec_take, 0);
          ie_set = 1'(e); stack_full = 1'(f);
          tick; ie_set = 0; #1;
          check("R7 ie set", ie, e);
          take = (p != 0) && e && !f;
          idx = (p != 0) ? low_idx(4'(p)) : 0;
          g = take ? 4'(1 << idx) : 4'd0;
          check("R4 take gate", vec_take, take);
          check("R2/R5 vec addr", vec_addr, take ? 4 * (idx + 1) : 0);
          check("R6 push", push_req, take);
          check("R6 ack", ack, g);
          tick; #1;
          check("R8/R9 pending after", pending, p & ~g);
          check("R7 ie cleared", ie, take ? 0 : e);
          stack_full = 0;
        end

    do_reset;
    drive_req(4'b0101, 0); tick; drive_req(4'd0, 0);
    for (int k = 0; k < 5; k++) tick;
    #1 check("R3 held", pending, 4'b0101);
    pend_clr = 4'b0001; req_ext = 1; tick; pend_clr = 0; req_ext = 0; #1;
    check("R10 set wins", pending, 4'b0101);
    pend_clr = 4'b0100; tick; pend_clr = 0; #1;
    check("R10 clear", pending, 4'b0001);
    ie_set = 1; ie_clr = 1; tick; ie_set = 0; ie_clr = 0; #1;
    check("R7 set over clr", ie, 1);
    req_ext = 1; ie_set = 1; tick; req_ext = 0; ie_set = 0; #1;
    check("R8 re-request kept", pending, 4'b0001);
    check("R7 take beats set", ie, 0);
    ie_clr = 1; tick; ie_clr = 0; #1;
    check("R7 clr", ie, 0);

    do_reset;
    drive_req(4'b1111, 0); tick; drive_req(4'd0, 0);
    for (int k = 0; k < 4; k++) begin
      ie_set = 1; tick; ie_set = 0; #1;
      check("R5 drain order", vec_addr, 4 * (k + 1));
      check("R6 drain ack", ack, 1 << k);
      tick;
    end
    #1 check("R8 drained", pending, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule